// File: doc/BRIEF.md
# Time-Redundant Segmented Adder with Self-Check

This block adds two `WIDTH`-bit operands and a carry-in over two evaluation cycles. It uses two adder segments, each `WIDTH/2` bits wide, and does not use a full-width duplicate adder. In the first evaluation cycle both segments add the same low halves of the operands together with the external carry-in. Their sums and carries must agree. The low half of the result and its carry come from segment 0. In the second evaluation cycle both segments add the high halves, using that stored carry as their carry-in, and their results are compared again. Any disagreement between the two segments in either cycle raises a sticky error flag.

A request is a one-cycle `start` pulse while the block is idle. The operands and carry-in are captured on that edge. The complete sum appears with a one-cycle `done` pulse. The result stays on the outputs until the next accepted request.

A fault-injection input lets a test flip a single output bit of one chosen segment. This proves that the comparison actually catches corrupted segment results.

Top module: `seg_dup_adder`

## Requirements
- R1: After reset, `sum`, `carryOut`, `done` and `error` are all 0.
- R2: For a request whose operands are captured on the start edge, the outputs present at `done` satisfy `{carryOut, sum} == opA + opB + carryIn`. The sum is `WIDTH+1` bits wide and the outputs come from segment 0.
- R3: The block samples `start` high at clock edge E0 while idle. `done` goes high after edge E0+2, stays high for exactly one cycle, and a new request may be sampled in that same cycle.
- R4: The carry out of the low half feeds the high half. For example, with WIDTH=16, 0x00FF + 0x0001 gives 0x0100.
- R5: With `faultEn` low, both segments agree in every evaluation cycle and `error` is 0 at `done`.
- R6: With `faultEn` high and `faultBit` below `WIDTH/2`, bit `faultBit` of the sum output of the segment chosen by `faultSeg` is inverted (0 = segment 0, 1 = segment 1). This sets `error`. A fault in segment 1 leaves `sum` and `carryOut` correct.
- R7: A `faultBit` value equal to `WIDTH/2` inverts the chosen segment's carry-out, and this also sets `error`.
- R8: A `faultBit` value above `WIDTH/2` has no effect: `error` stays 0 and the result is correct.
- R9: `error` stays set until the next accepted `start`, which clears it.
- R10: A `start` pulse while a request is in progress is ignored. The result and the `done` timing follow the request already in progress.
- R11: Between `done` and the next accepted request, `sum`, `carryOut` and `error` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into the least significant bit |
| faultEn | input | 1 | Test-only: enable fault injection |
| faultSeg | input | 1 | Test-only: segment to corrupt (0 or 1) |
| faultBit | input | $clog2(WIDTH/2+1) | Test-only: bit to invert; WIDTH/2 selects the carry-out |
| sum | output | WIDTH | Sum result |
| carryOut | output | 1 | Final carry-out |
| done | output | 1 | One-cycle result-valid pulse |
| error | output | 1 | Sticky segment-disagreement flag |

## Verification
The segment-agreement assertion assumes that `faultEn` is low whenever the fault path is not under test. The bench drives the fault inputs only together with a request and holds them steady for the whole request.

The request-sequencing assertions assume that `start` is a synchronous pulse. The bench drives it away from the clock edge, and it raises `start` during a busy cycle only on purpose, to test R10.

Random operands, carries and fault settings are mixed with directed carry-chain cases. The fault bit ranges over values beyond the carry-out index, so every fault selection is reached.

// File: rtl/seg_dup_adder_pkg.sv
package seg_dup_adder_pkg;
  typedef struct packed {
    logic loadOps;   // capture operands, clear error
    logic evalLow;   // both segments add the low halves
    logic evalHigh;  // both segments add the high halves
  } ctrlStrobes_t;
endpackage

// File: rtl/seg_adder_slice.sv
module seg_adder_slice #(
  parameter int HALF  = 8,
  parameter int FBW   = 4,
  parameter int SEGID = 0
) (
  input  logic [HALF-1:0] a,
  input  logic [HALF-1:0] b,
  input  logic            cin,
  input  logic            faultEn,
  input  logic            faultSeg,
  input  logic [FBW-1:0]  faultBit,
  output logic [HALF:0]   res
);
  logic [HALF:0] rawSum;
  logic [HALF:0] flipMask;
  logic          hitMe;

  assign hitMe  = faultEn && (faultSeg == 1'(SEGID));
  assign rawSum = {1'b0, a} + {1'b0, b} + {{HALF{1'b0}}, cin};

  always_comb begin
    for (int i = 0; i <= HALF; i++) begin
      flipMask[i] = hitMe && (faultBit == FBW'(i));
    end
  end

  assign res = rawSum ^ flipMask;
endmodule

// File: rtl/seg_dup_adder_ctrl.sv
module seg_dup_adder_ctrl
  import seg_dup_adder_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         done
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} state_t;
  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      ST_IDLE: if (start) begin
        strobes.loadOps = 1'b1;
        stateNext       = ST_LOW;
      end
      ST_LOW: begin
        strobes.evalLow = 1'b1;
        stateNext       = ST_HIGH;
      end
      ST_HIGH: begin
        strobes.evalHigh = 1'b1;
        stateNext        = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobes.evalHigh;
    end
  end

  // R10: the low phase always advances to the high phase; start cannot divert it
  assert_low_then_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evalLow |=> strobes.evalHigh);
  // R3: an accepted request enters the low phase on the next cycle
  assert_load_then_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadOps |=> strobes.evalLow);
  // R3: done pulses right after the high phase and lasts a single cycle
  assert_done_after_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evalHigh |=> done);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/seg_dup_adder_dp.sv
module seg_dup_adder_dp
  import seg_dup_adder_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int HALF  = WIDTH / 2,
  parameter int FBW   = $clog2(HALF + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic             faultEn,
  input  logic             faultSeg,
  input  logic [FBW-1:0]   faultBit,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             error
);
  logic [WIDTH-1:0] opAReg, opBReg;
  logic             cinReg, midCarry;
  logic [HALF-1:0]  segA, segB;
  logic             segCin;
  logic [HALF:0]    segRes [2];
  logic             mismatch;
  logic             evalAny;

  assign evalAny = strobes.evalLow || strobes.evalHigh;
  assign segA    = strobes.evalHigh ? opAReg[WIDTH-1:HALF] : opAReg[HALF-1:0];
  assign segB    = strobes.evalHigh ? opBReg[WIDTH-1:HALF] : opBReg[HALF-1:0];
  assign segCin  = strobes.evalHigh ? midCarry : cinReg;

  for (genvar g = 0; g < 2; g++) begin : gSeg
    seg_adder_slice #(.HALF(HALF), .FBW(FBW), .SEGID(g)) u_slice (
      .a(segA), .b(segB), .cin(segCin),
      .faultEn(faultEn), .faultSeg(faultSeg), .faultBit(faultBit),
      .res(segRes[g])
    );
  end

  assign mismatch = segRes[0] != segRes[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAReg   <= '0;
      opBReg   <= '0;
      cinReg   <= 1'b0;
      midCarry <= 1'b0;
      sum      <= '0;
      carryOut <= 1'b0;
      error    <= 1'b0;
    end else begin
      if (strobes.loadOps) begin
        opAReg <= opA;
        opBReg <= opB;
        cinReg <= carryIn;
        error  <= 1'b0;
      end
      if (strobes.evalLow) begin
        sum[HALF-1:0] <= segRes[0][HALF-1:0];
        midCarry      <= segRes[0][HALF];
      end
      if (strobes.evalHigh) begin
        sum[WIDTH-1:HALF] <= segRes[0][HALF-1:0];
        carryOut          <= segRes[0][HALF];
      end
      if (evalAny && mismatch) error <= 1'b1;
    end
  end

  // R5: two independent slices must agree whenever no fault is injected
  assert_segments_agree_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evalAny && !faultEn) |-> (segRes[0] == segRes[1]));
  // R4: the low half written in the low phase survives the high phase
  assert_low_half_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evalHigh |=> $stable(sum[HALF-1:0]));
  // R11: outside a request the visible result does not move
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!evalAny && !strobes.loadOps) |=> ($stable(sum) && $stable(carryOut) && $stable(error)));
endmodule

// File: rtl/seg_dup_adder.sv
module seg_dup_adder
  import seg_dup_adder_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int HALF = WIDTH / 2,
  localparam int FBW  = $clog2(HALF + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic             faultEn,
  input  logic             faultSeg,
  input  logic [FBW-1:0]   faultBit,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             done,
  output logic             error
);
  ctrlStrobes_t strobes;

  initial begin
    assert_even_width: assert ((WIDTH % 2) == 0 && WIDTH >= 2);
  end

  seg_dup_adder_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strobes(strobes), .done(done)
  );

  seg_dup_adder_dp #(.WIDTH(WIDTH), .HALF(HALF), .FBW(FBW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .faultEn(faultEn), .faultSeg(faultSeg), .faultBit(faultBit),
    .sum(sum), .carryOut(carryOut), .error(error)
  );
endmodule

// File: tb/seg_dup_adder_bench.sv
module seg_dup_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 16;
  localparam int HALF  = WIDTH / 2;
  localparam int FBW   = $clog2(HALF + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [WIDTH-1:0] opA = '0, opB = '0;
  logic carryIn = 1'b0, faultEn = 1'b0, faultSeg = 1'b0;
  logic [FBW-1:0] faultBit = '0;
  logic [WIDTH-1:0] sum;
  logic carryOut, done, error;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_dup_adder #(.WIDTH(WIDTH)) u_seg_dup_adder (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .carryIn(carryIn), .faultEn(faultEn), .faultSeg(faultSeg),
    .faultBit(faultBit), .sum(sum), .carryOut(carryOut),
    .done(done), .error(error)
  );

  function automatic logic [WIDTH:0] expSum(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, c};
  endfunction

  function automatic logic expErr(logic fe, logic [FBW-1:0] fb);
    return fe && (int'(fb) <= HALF);
  endfunction

  task automatic check(string req, logic [WIDTH:0] act, logic [WIDTH:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start sampled at the next edge (E0); returns at the negedge after E0+2
  task automatic runOp(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, logic c,
                       logic fe, logic fs, logic [FBW-1:0] fb, string req);
    logic [WIDTH:0] e;
    logic faultSumPath;
    opA = a; opB = b; carryIn = c; faultEn = fe; faultSeg = fs; faultBit = fb;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check({req, " R3 done low mid-request"}, {{WIDTH{1'b0}}, done}, '0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check({req, " R3 done"}, {{WIDTH{1'b0}}, done}, 1);
    e = expSum(a, b, c);
    check({req, " R6 R7 R8 R5 error"}, {{WIDTH{1'b0}}, error}, {{WIDTH{1'b0}}, expErr(fe, fb)});
    faultSumPath = expErr(fe, fb) && !fs;
    if (!faultSumPath) check({req, " R2 sum"}, {carryOut, sum}, e);
    faultEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [WIDTH:0] held;
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 2);
    @(negedge clk);
    // R1 reset state
    check("R1 reset", {carryOut, sum}, '0);
    check("R1 reset done/error", {{(WIDTH-1){1'b0}}, done, error}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 carry chain across halves
    runOp(16'h00FF, 16'h0001, 1'b0, 1'b0, 1'b0, '0, "R4 mid carry");
    check("R4 value", {carryOut, sum}, 17'h00100);
    runOp(16'hFFFF, 16'h0000, 1'b1, 1'b0, 1'b0, '0, "R4 full ripple");
    check("R4 wrap", {carryOut, sum}, 17'h10000);
    runOp(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, '0, "R2 max");

    // R6 fault in segment 0 and segment 1
    runOp(16'h1234, 16'h4321, 1'b0, 1'b1, 1'b0, FBW'(3), "R6 seg0");
    // R11 hold after done
    held = {carryOut, sum};
    @(negedge clk); @(negedge clk);
    check("R11 hold sum", {carryOut, sum}, held);
    check("R11 hold error", {{WIDTH{1'b0}}, error}, 1);
    check("R3 done single", {{WIDTH{1'b0}}, done}, '0);
    // R9 next clean request clears error
    runOp(16'h0F0F, 16'h0101, 1'b0, 1'b0, 1'b0, '0, "R9 cleared");
    runOp(16'hABCD, 16'h1111, 1'b1, 1'b1, 1'b1, FBW'(7), "R6 seg1");
    // R7 carry-out fault, R8 out-of-range index
    runOp(16'h00F0, 16'h0020, 1'b0, 1'b1, 1'b0, FBW'(HALF), "R7 seg0 carry");
    runOp(16'h80F0, 16'h8020, 1'b0, 1'b1, 1'b1, FBW'(HALF), "R7 seg1 carry");
    runOp(16'h5555, 16'hAAAA, 1'b1, 1'b1, 1'b0, FBW'(HALF + 1), "R8 ignored");

    // R10 start while busy is ignored
    opA = 16'h0102; opB = 16'h0304; carryIn = 1'b0; start = 1'b1;
    @(posedge clk); @(negedge clk);
    opA = 16'hFFFF; opB = 16'hFFFF; carryIn = 1'b1; // start still high: busy
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check("R10 done not early", {{WIDTH{1'b0}}, done}, '0);
    @(posedge clk); @(negedge clk);
    check("R10 done", {{WIDTH{1'b0}}, done}, 1);
    check("R10 sum", {carryOut, sum}, 17'h00406);
    @(negedge clk);
    check("R10 no second done", {{WIDTH{1'b0}}, done}, '0);

    // R3 back-to-back: request sampled in the done cycle
    opA = 16'h0011; opB = 16'h0022; carryIn = 1'b0; start = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    start = 1'b0;
    check("R3 b2b first done", {{WIDTH{1'b0}}, done}, 1);
    runOp(16'h7000, 16'h9000, 1'b0, 1'b0, 1'b0, '0, "R3 b2b second");
    check("R4 top carry", {carryOut, sum}, 17'h10000);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic fe;
      fe = ($urandom % 2) == 1;
      runOp(WIDTH'($urandom), WIDTH'($urandom), 1'($urandom), fe, 1'($urandom),
            FBW'($urandom % (HALF + 4)), "rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule